// File: doc/BRIEF.md
# Locked Atomic Read-Modify-Write Unit

This unit sits between several hardware threads and a small shared word store and carries out indivisible read-modify-write operations: compare-and-swap, increment, add and exchange. A single global lock register names the thread, if any, that has exclusive access to the store. A thread raises its request with an operation code, an address and its operands, and holds them until its done pulse. Each thread also reports whether its write buffer is empty. The lock is granted only while it is free and the requester's buffer is empty. While a thread holds the lock, every other thread sees a blocked indication, which its buffer drain and its plain loads must honour.

The sequencer walks through named states. ST_IDLE goes to ST_ACQUIRE when the arbiter grants an eligible request. That transition takes the lock and latches the operands. ST_ACQUIRE goes to ST_READ. ST_READ fetches the old word and goes to ST_MODIFY. ST_MODIFY computes the new word and the flag, then goes to ST_WRITE if a store is needed and to ST_RELEASE otherwise. ST_WRITE stores the word and goes to ST_RELEASE. ST_RELEASE waits until the owner's buffer is empty, then frees the lock, pulses done with the result and flag, and returns to ST_IDLE.

When several threads are eligible in the same cycle, a round-robin arbiter chooses one. Its search starts just after the most recent winner. The other requests stay pending and are served later.

Top module: `rmw_lock_unit`

## Requirements
- R1: After reset the lock is free, no thread is blocked, and no done pulse is present.
- R2: The lock is taken only when it is free and the requester's `buf_empty_i` bit is 1. A request made while that bit is 0 takes no lock and produces no done pulse until the bit rises. The owner does not change while the lock is held.
- R3: The lock is released only while the owner's `buf_empty_i` bit is 1. If the bit is 0 in ST_RELEASE, the lock stays held and done is withheld.
- R4: Compare-and-swap (op 2'b00) with `cmp_i` equal to the stored word sets the flag to 1, returns the old word and stores `src_i`.
- R5: Compare-and-swap with `cmp_i` different from the stored word clears the flag to 0, returns the stored word and leaves the store unchanged.
- R6: Increment (op 2'b01) returns the old word and stores old+1 modulo 2^DW. Two increments of a word that starts at 0 leave 2.
- R7: Add (op 2'b10) returns the old word and stores old+`src_i` modulo 2^DW. For increment, add and exchange, the flag is 1 exactly when the stored word is zero.
- R8: Exchange (op 2'b11) returns the old word and stores `src_i`.
- R9: While the lock is held, `blocked_o` is 1 for every thread except the owner and 0 for the owner. While the lock is free, `blocked_o` is all zero.
- R10: Among requests that are eligible in the same cycle, the winner is the first requesting thread found by searching upward, with wrap-around, from the previous winner plus one. The search starts at thread 0 after reset. The losers stay pending and are each served later.
- R11: Each operation ends with a done pulse of exactly one cycle, at most one bit set, on the owner's bit. The pulse arrives with `result_o` and `zf_o` and in the cycle the lock becomes free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N_THR | Per-thread request, held until that thread's done pulse |
| op_i | input | 2*N_THR | Per-thread operation code, 2 bits per thread |
| addr_i | input | AW*N_THR | Per-thread word address |
| src_i | input | DW*N_THR | Per-thread source operand |
| cmp_i | input | DW*N_THR | Per-thread compare (accumulator) operand |
| buf_empty_i | input | N_THR | Per-thread write-buffer-empty status |
| done_o | output | N_THR | One-cycle completion pulse, on the owner's bit |
| result_o | output | DW | Old word read by the operation |
| zf_o | output | 1 | Zero/compare flag |
| blocked_o | output | N_THR | Per-thread blocked indication while another thread owns the lock |
| lock_held_o | output | 1 | Lock is held |
| lock_owner_o | output | OW | Index of the current or most recent owner |

## Verification
Two pairs of functions can fall in the same cycle. The first is arbitration: several threads raise requests on the same edge while a shared word is being incremented. The winner order is computed from the previous winner, and the returned old values must form an unbroken count, so a lost update shows up as a repeated value. The second is a release that meets a waiting request: a held lock with the owner's buffer forced non-empty must neither release nor pulse done, and the thread that was kept pending by its own buffer must take the lock only after that buffer empties.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
    typedef enum logic [1:0] {
        OP_CAS  = 2'b00,
        OP_INC  = 2'b01,
        OP_ADD  = 2'b10,
        OP_XCHG = 2'b11
    } rmw_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQUIRE,
        ST_READ,
        ST_MODIFY,
        ST_WRITE,
        ST_RELEASE
    } rmw_state_e;
endpackage

// File: rtl/rmw_rr_arb.sv
module rmw_rr_arb #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          adv,
    output logic          any,
    output logic [IW-1:0] win
);
    logic [IW-1:0] last_q;

    always_comb begin
        any = 1'b0;
        win = '0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last_q) + k) % N;
            if (!any && req[idx]) begin
                any = 1'b1;
                win = IW'(idx);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            last_q <= IW'(N - 1);
        else if (adv && any)
            last_q <= win;
    end
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
    import rmw_pkg::*;
#(
    parameter int DW = 8
) (
    input  rmw_op_e       op,
    input  logic [DW-1:0] old,
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] cmp,
    output logic [DW-1:0] nxt,
    output logic          wr,
    output logic          zf
);
    always_comb begin
        nxt = old;
        wr  = 1'b1;
        zf  = 1'b0;
        unique case (op)
            OP_CAS: begin
                wr  = (old == cmp);
                zf  = (old == cmp);
                nxt = (old == cmp) ? src : old;
            end
            OP_INC:  nxt = old + DW'(1);
            OP_ADD:  nxt = old + src;
            OP_XCHG: nxt = src;
            default: nxt = old;
        endcase
        if (op != OP_CAS)
            zf = (nxt == '0);
    end
endmodule

// File: rtl/rmw_store.sv
module rmw_store #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem_q [DEPTH];

    assign rdata = mem_q[addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= '0;
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end
endmodule

// File: rtl/rmw_lock_unit.sv
module rmw_lock_unit
    import rmw_pkg::*;
#(
    parameter int N_THR = 4,
    parameter int AW    = 4,
    parameter int DW    = 8,
    localparam int OW   = (N_THR > 1) ? $clog2(N_THR) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_THR-1:0]    req_i,
    input  logic [2*N_THR-1:0]  op_i,
    input  logic [AW*N_THR-1:0] addr_i,
    input  logic [DW*N_THR-1:0] src_i,
    input  logic [DW*N_THR-1:0] cmp_i,
    input  logic [N_THR-1:0]    buf_empty_i,
    output logic [N_THR-1:0]    done_o,
    output logic [DW-1:0]       result_o,
    output logic                zf_o,
    output logic [N_THR-1:0]    blocked_o,
    output logic                lock_held_o,
    output logic [OW-1:0]       lock_owner_o
);
    rmw_state_e    state_q, state_d;
    logic          lock_vld_q;
    logic [OW-1:0] own_q;
    rmw_op_e       op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] src_q, cmp_q, old_q, new_q, rd_data;
    logic          zf_q;
    logic [N_THR-1:0] done_q;
    logic [DW-1:0] res_q;
    logic          zfo_q;

    logic          any_g;
    logic [OW-1:0] win_idx;
    logic [DW-1:0] alu_new;
    logic          alu_wr, alu_zf;

    rmw_rr_arb #(.N(N_THR), .IW(OW)) arb_i (
        .clk (clk),
        .rst_n (rst_n),
        .req (req_i & buf_empty_i),
        .adv (state_q == ST_IDLE),
        .any (any_g),
        .win (win_idx)
    );

    rmw_alu #(.DW(DW)) alu_i (
        .op (op_q), .old (old_q), .src (src_q), .cmp (cmp_q),
        .nxt (alu_new), .wr (alu_wr), .zf (alu_zf)
    );

    rmw_store #(.AW(AW), .DW(DW)) store_i (
        .clk (clk), .rst_n (rst_n),
        .we (state_q == ST_WRITE),
        .addr (addr_q), .wdata (new_q), .rdata (rd_data)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (any_g) state_d = ST_ACQUIRE;
            ST_ACQUIRE: state_d = ST_READ;
            ST_READ:    state_d = ST_MODIFY;
            ST_MODIFY:  state_d = alu_wr ? ST_WRITE : ST_RELEASE;
            ST_WRITE:   state_d = ST_RELEASE;
            ST_RELEASE: if (buf_empty_i[own_q]) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_vld_q <= 1'b0;
            own_q      <= '0;
            op_q       <= OP_CAS;
            addr_q     <= '0;
            src_q      <= '0;
            cmp_q      <= '0;
            old_q      <= '0;
            new_q      <= '0;
            zf_q       <= 1'b0;
            done_q     <= '0;
            res_q      <= '0;
            zfo_q      <= 1'b0;
        end else begin
            done_q <= '0;
            unique case (state_q)
                ST_IDLE: if (any_g) begin
                    lock_vld_q <= 1'b1;
                    own_q      <= win_idx;
                    op_q       <= rmw_op_e'(op_i[int'(win_idx)*2 +: 2]);
                    addr_q     <= addr_i[int'(win_idx)*AW +: AW];
                    src_q      <= src_i[int'(win_idx)*DW +: DW];
                    cmp_q      <= cmp_i[int'(win_idx)*DW +: DW];
                end
                ST_READ: old_q <= rd_data;
                ST_MODIFY: begin
                    new_q <= alu_new;
                    zf_q  <= alu_zf;
                end
                ST_RELEASE: if (buf_empty_i[own_q]) begin
                    lock_vld_q    <= 1'b0;
                    done_q[own_q] <= 1'b1;
                    res_q         <= old_q;
                    zfo_q         <= zf_q;
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < N_THR; g++) begin : g_blk
        assign blocked_o[g] = lock_vld_q && (own_q != OW'(g));
    end

    assign done_o       = done_q;
    assign result_o     = res_q;
    assign zf_o         = zfo_q;
    assign lock_held_o  = lock_vld_q;
    assign lock_owner_o = own_q;
endmodule

// File: rtl/rmw_lock_unit_chk.sv
module rmw_lock_unit_chk #(
    parameter int N  = 4,
    parameter int OW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  req_i,
    input logic [N-1:0]  buf_empty_i,
    input logic [N-1:0]  done_o,
    input logic [N-1:0]  blocked_o,
    input logic          lock_held_o,
    input logic [OW-1:0] lock_owner_o
);
    assert_acquire_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_held_o) |-> ((($past(req_i & buf_empty_i) >> lock_owner_o) & N'(1)) != '0));

    assert_owner_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_held_o && $past(lock_held_o)) |-> $stable(lock_owner_o));

    assert_release_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_held_o) |-> $past(buf_empty_i[lock_owner_o]));

    assert_blocked_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(blocked_o) == (lock_held_o ? N - 1 : 0));

    assert_done_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_o));

    assert_done_at_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o != '0) |-> (!lock_held_o && $past(lock_held_o)));
endmodule

bind rmw_lock_unit rmw_lock_unit_chk #(.N(N_THR), .OW(OW)) chk_i (
    .clk (clk),
    .rst_n (rst_n),
    .req_i (req_i),
    .buf_empty_i (buf_empty_i),
    .done_o (done_o),
    .blocked_o (blocked_o),
    .lock_held_o (lock_held_o),
    .lock_owner_o (lock_owner_o)
);

// File: tb/rmw_lock_unit_tb_top.sv
module rmw_lock_unit_tb_top;
    localparam int N  = 4;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int OW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]    req_i = '0;
    logic [2*N-1:0]  op_i = '0;
    logic [AW*N-1:0] addr_i = '0;
    logic [DW*N-1:0] src_i = '0;
    logic [DW*N-1:0] cmp_i = '0;
    logic [N-1:0]    buf_empty_i = '1;
    logic [N-1:0]    done_o;
    logic [DW-1:0]   result_o;
    logic            zf_o;
    logic [N-1:0]    blocked_o;
    logic            lock_held_o;
    logic [OW-1:0]   lock_owner_o;

    int checks = 0;
    int errors = 0;
    int last_win = N - 1;
    int cycles = 0;

    always #5 clk = ~clk;

    rmw_lock_unit #(.N_THR(N), .AW(AW), .DW(DW)) dut_i (
        .clk (clk), .rst_n (rst_n), .req_i (req_i), .op_i (op_i),
        .addr_i (addr_i), .src_i (src_i), .cmp_i (cmp_i),
        .buf_empty_i (buf_empty_i), .done_o (done_o), .result_o (result_o),
        .zf_o (zf_o), .blocked_o (blocked_o), .lock_held_o (lock_held_o),
        .lock_owner_o (lock_owner_o)
    );

    // {thread[2], op[2], addr[4], src[8], cmp[8], expected result[8], expected flag[1]}
    localparam logic [32:0] VEC [12] = '{
        {2'd0, 2'b11, 4'h3, 8'h55, 8'h00, 8'h00, 1'b0},
        {2'd1, 2'b00, 4'h3, 8'h77, 8'h55, 8'h55, 1'b1},
        {2'd2, 2'b00, 4'h3, 8'h99, 8'h10, 8'h77, 1'b0},
        {2'd3, 2'b11, 4'h3, 8'h00, 8'h00, 8'h77, 1'b1},
        {2'd0, 2'b01, 4'h5, 8'h00, 8'h00, 8'h00, 1'b0},
        {2'd1, 2'b01, 4'h5, 8'h00, 8'h00, 8'h01, 1'b0},
        {2'd2, 2'b11, 4'h5, 8'h00, 8'h00, 8'h02, 1'b1},
        {2'd3, 2'b10, 4'h7, 8'hF0, 8'h00, 8'h00, 1'b0},
        {2'd0, 2'b10, 4'h7, 8'h10, 8'h00, 8'hF0, 1'b1},
        {2'd1, 2'b11, 4'h7, 8'hFF, 8'h00, 8'h00, 1'b0},
        {2'd2, 2'b01, 4'h7, 8'h00, 8'h00, 8'hFF, 1'b1},
        {2'd3, 2'b11, 4'h7, 8'h01, 8'h00, 8'h00, 1'b0}
    };

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            finish_run();
        end
    end

    task automatic load(input int t, input logic [1:0] op, input logic [3:0] a,
                        input logic [7:0] s, input logic [7:0] c);
        op_i[t*2 +: 2]   = op;
        addr_i[t*AW +: AW] = a;
        src_i[t*DW +: DW] = s;
        cmp_i[t*DW +: DW] = c;
    endtask

    task automatic wait_done(input int t, output logic [7:0] r, output logic z, output bit ok);
        ok = 0;
        r = '0;
        z = 1'b0;
        for (int i = 0; i < 80 && !ok; i++) begin
            @(negedge clk);
            if (done_o[t]) begin
                ok = 1;
                r = result_o;
                z = zf_o;
                req_i[t] = 1'b0;
                last_win = t;
            end
        end
    endtask

    function automatic string tag_of(input logic [1:0] op, input logic zf);
        case (op)
            2'b00:   return zf ? "R4" : "R5";
            2'b01:   return "R6";
            2'b10:   return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic multi(input logic [N-1:0] set, input logic [3:0] a, input logic [7:0] base);
        int exp_order [N];
        int got_order [N];
        logic [7:0] got_res [N];
        logic [N-1:0] pend;
        int last;
        int cnt;
        int n;
        pend = set;
        last = last_win;
        cnt = $countones(set);
        for (int k = 0; k < cnt; k++) begin
            bit found;
            found = 0;
            for (int j = 1; j <= N; j++) begin
                int idx;
                idx = (last + j) % N;
                if (!found && pend[idx]) begin
                    found = 1;
                    exp_order[k] = idx;
                    pend[idx] = 1'b0;
                    last = idx;
                end
            end
        end
        @(negedge clk);
        for (int t = 0; t < N; t++)
            if (set[t]) load(t, 2'b01, a, 8'h00, 8'h00);
        req_i = req_i | set;
        n = 0;
        for (int i = 0; i < 300 && n < cnt; i++) begin
            @(negedge clk);
            for (int t = 0; t < N; t++) begin
                if (done_o[t]) begin
                    got_order[n] = t;
                    got_res[n] = result_o;
                    req_i[t] = 1'b0;
                    last_win = t;
                    n++;
                end
            end
        end
        chk(n == cnt, "R10 all pending requests served", n, cnt);
        for (int k = 0; k < cnt && k < n; k++) begin
            chk(got_order[k] == exp_order[k], "R10 round-robin order", got_order[k], exp_order[k]);
            chk(got_res[k] == base + 8'(k), "R6 no lost update", got_res[k], base + 8'(k));
        end
    endtask

    initial begin
        logic [7:0] r;
        logic z;
        bit ok;

        repeat (3) @(negedge clk);
        chk(lock_held_o == 1'b0, "R1 lock free after reset", lock_held_o, 0);
        chk(blocked_o == '0, "R1 nothing blocked after reset", blocked_o, 0);
        chk(done_o == '0, "R1 no done after reset", done_o, 0);
        rst_n = 1'b1;

        for (int v = 0; v < 12; v++) begin
            int t;
            logic [32:0] e;
            e = VEC[v];
            t = int'(e[32:31]);
            @(negedge clk);
            load(t, e[30:29], e[28:25], e[24:17], e[16:9]);
            req_i[t] = 1'b1;
            wait_done(t, r, z, ok);
            chk(ok, "R11 done pulse arrives", ok, 1);
            chk(r == e[8:1], tag_of(e[30:29], e[0]), r, e[8:1]);
            chk(z == e[0], "R7 flag value", z, e[0]);
            chk(lock_held_o == 1'b0, "R11 lock free with done", lock_held_o, 0);
            @(negedge clk);
            chk(done_o == '0, "R11 done lasts one cycle", done_o, 0);
        end

        // R2: requester with a non-empty buffer waits without the lock
        @(negedge clk);
        buf_empty_i[1] = 1'b0;
        load(1, 2'b01, 4'h9, 8'h00, 8'h00);
        req_i[1] = 1'b1;
        begin
            bit held;
            held = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (lock_held_o || done_o != '0) held = 1;
            end
            chk(!held, "R2 no lock while buffer not empty", held, 0);
        end
        buf_empty_i[1] = 1'b1;
        wait_done(1, r, z, ok);
        chk(ok && r == 8'h00, "R2 proceeds after buffer empties", r, 0);

        // R9: blocked indications while thread 2 owns the lock
        @(negedge clk);
        load(2, 2'b01, 4'h9, 8'h00, 8'h00);
        req_i[2] = 1'b1;
        begin
            bit seen;
            seen = 0;
            for (int i = 0; i < 10 && !seen; i++) begin
                @(negedge clk);
                if (lock_held_o) begin
                    seen = 1;
                    chk(blocked_o == 4'b1011, "R9 others blocked", blocked_o, 4'b1011);
                    chk(lock_owner_o == 2'd2, "R9 owner index", lock_owner_o, 2);
                end
            end
            chk(seen, "R9 lock observed held", seen, 1);
        end
        wait_done(2, r, z, ok);
        chk(ok && r == 8'h01, "R6 increment returns old", r, 1);
        @(negedge clk);
        chk(blocked_o == '0, "R9 none blocked when free", blocked_o, 0);

        // R3: owner buffer refills before release
        @(negedge clk);
        load(0, 2'b11, 4'hC, 8'h3C, 8'h00);
        req_i[0] = 1'b1;
        for (int i = 0; i < 10 && !lock_held_o; i++) @(negedge clk);
        buf_empty_i[0] = 1'b0;
        begin
            bit bad;
            bad = 0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (!lock_held_o || done_o != '0) bad = 1;
            end
            chk(!bad, "R3 lock kept while owner buffer not empty", bad, 0);
        end
        buf_empty_i[0] = 1'b1;
        wait_done(0, r, z, ok);
        chk(ok && r == 8'h00, "R3 release after buffer empties", r, 0);

        // R10: simultaneous requests, word 9 now holds 2
        multi(4'b1010, 4'h9, 8'h02);
        multi(4'b1101, 4'hB, 8'h00);
        multi(4'b1111, 4'h9, 8'h04);

        finish_run();
    end
endmodule